// File: doc/BRIEF.md
# Decimating FIR Filter with Mirrored-Tap Pre-Adder

This block filters a stream of signed 16-bit real samples and keeps one result for each group of accepted inputs. The group size is set by a decimation code. One multiply-accumulate unit is shared in time across the taps. In symmetric mode, the two samples that share a coefficient are combined before the multiply, so a filter of N taps needs only ceil(N/2) multiply steps. In asymmetric mode, each tap needs its own step. A higher decimation code gives more clocks per result, so a longer filter fits into one result period.

Coefficients are held in a 32-entry bank that is written through an address/data port. Samples go into a circular history buffer, which is cleared by reset. Each result is computed from the history as it stood when the decimating input arrived. A controller with three states sequences each result:

- ST_IDLE waits for the decimating input. On it, the controller moves to ST_MAC, or goes straight to ST_EMIT when zero steps are needed.
- ST_MAC runs one tap step per clock. After the last step it moves to ST_EMIT.
- ST_EMIT rounds and saturates the sum and presents it. It then returns to ST_IDLE. If the next decimating input arrives in that same cycle, it starts a new result in ST_MAC or ST_EMIT instead.

Inputs must be spaced at least `CLKS_PER_IN` clocks apart. Configuration must be held stable while the filter runs.

Top module: `symfir_decim`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `over_budget` are all 0, and `out_valid` stays 0 in the first cycle after reset is released.
- R2: With decimation code c, exactly one result is produced for every c+1 accepted inputs. The first result belongs to input number c (counting from 0).
- R3: With `cfg_sym`=1 and `cfg_odd_sym`=0, the result for input n is the sum over j < floor(N/2) of h[j]·(x[n−j]+x[n−N+1+j]). When N is odd, h[(N−1)/2]·x[n−(N−1)/2] is added. Coefficient h[j] is read from bank address j.
- R4: With `cfg_sym`=1 and `cfg_odd_sym`=1, each pair is subtracted as h[j]·(x[n−j]−x[n−N+1+j]). For an odd N, the centre tap contributes zero.
- R5: With `cfg_sym`=0, the result is the sum over j < N of h[j]·x[n−j]. N is clamped to 32, and N=0 gives a result of 0.
- R6: The sum is treated as Q15. It is scaled by 2^-15, rounded by adding 2^14 and shifting arithmetically, and saturated to the range −32768..32767.
- R7: The steps needed are ceil(N/2) in symmetric mode and N in asymmetric mode. The budget is (c+1)·CLKS_PER_IN−1. When the need exceeds the budget, `over_budget` reads 1 from the next cycle on, and only steps j < budget are summed.
- R8: `out_valid` is a single-cycle pulse, and `out_data` changes only in a cycle where `out_valid` is 1.
- R9: Samples older than the first one accepted after reset count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_sym | input | 1 | 1 = symmetric mode, 0 = asymmetric mode |
| cfg_odd_sym | input | 1 | 1 = odd (negated) symmetry, 0 = even symmetry |
| cfg_taps | input | 6 | Tap count N |
| cfg_dec | input | 3 | Decimation code c (one output per c+1 inputs) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Coefficient bank address |
| coef_data | input | 16 | Signed Q15 coefficient |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Rounded, saturated result |
| over_budget | output | 1 | Tap steps exceed the clocks available per result |

## Verification
The bench builds the block with its default parameters: a 63-tap symmetric limit, a 32-tap asymmetric limit, a 3-bit decimation code, five clocks per input and a 128-entry history. At decimation codes 6 and 7, these settings allow the full 63-tap symmetric filter and the 32-tap asymmetric filter to complete. At codes 0 and 1, they let short filters exceed the budget, so truncation can be checked. The bench covers all four pairings of symmetry type and tap-count parity, plus the asymmetric mode, a zero-tap filter and both saturation rails.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_EMIT
    } fir_state_e;
endpackage

// File: rtl/symfir_sample_ring.sv
module symfir_sample_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    output logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_a,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_b,
    output logic signed [DATA_W-1:0] rd_a,
    output logic signed [DATA_W-1:0] rd_b
);
    localparam int AW = $clog2(DEPTH);

    logic signed [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]            ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[ptr_q] <= wr_data;
            ptr_q        <= ptr_q + AW'(1);
        end
    end

    assign wr_ptr = ptr_q;
    assign rd_a   = mem_q[rd_addr_a];
    assign rd_b   = mem_q[rd_addr_b];
endmodule

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank #(
    parameter int COEF_W = 16,
    parameter int N_COEF = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(N_COEF)-1:0] waddr,
    input  logic signed [COEF_W-1:0]  wdata,
    input  logic [$clog2(N_COEF)-1:0] raddr,
    output logic signed [COEF_W-1:0]  rdata
);
    logic signed [COEF_W-1:0] bank_q [N_COEF];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++) begin
                bank_q[i] <= '0;
            end
        end else if (we) begin
            bank_q[waddr] <= wdata;
        end
    end

    assign rdata = bank_q[raddr];
endmodule

// File: rtl/symfir_round_sat.sv
module symfir_round_sat #(
    parameter int ACC_W = 38,
    parameter int FRAC  = 15,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAX_V    = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V    = -MAX_V - ACC_W'(1);

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        biased = acc + HALF_LSB;
        scaled = biased >>> FRAC;
        if (scaled > MAX_V) begin
            y = MAX_V[OUT_W-1:0];
        end else if (scaled < MIN_V) begin
            y = MIN_V[OUT_W-1:0];
        end else begin
            y = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/symfir_decim.sv
module symfir_decim
    import symfir_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int COEF_W        = 16,
    parameter int MAX_SYM_TAPS  = 63,
    parameter int MAX_ASYM_TAPS = 32,
    parameter int TAPS_W        = 6,
    parameter int DEC_W         = 3,
    parameter int CLKS_PER_IN   = 5,
    parameter int RING_DEPTH    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_sym,
    input  logic              cfg_odd_sym,
    input  logic [TAPS_W-1:0] cfg_taps,
    input  logic [DEC_W-1:0]  cfg_dec,
    input  logic              coef_we,
    input  logic [$clog2(((MAX_SYM_TAPS + 1) / 2 > MAX_ASYM_TAPS) ? (MAX_SYM_TAPS + 1) / 2 : MAX_ASYM_TAPS)-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              over_budget
);
    localparam int N_COEF  = ((MAX_SYM_TAPS + 1) / 2 > MAX_ASYM_TAPS) ? (MAX_SYM_TAPS + 1) / 2 : MAX_ASYM_TAPS;
    localparam int CADDR_W = $clog2(N_COEF);
    localparam int RING_AW = $clog2(RING_DEPTH);
    localparam int PRE_W   = DATA_W + 1;
    localparam int PROD_W  = PRE_W + COEF_W;
    localparam int ACC_W   = PROD_W + $clog2(N_COEF);
    localparam int FRAC    = COEF_W - 1;

    fir_state_e state_q, state_d;

    logic [DEC_W-1:0]         phase_q;
    logic [RING_AW-1:0]       base_q;
    logic [TAPS_W-1:0]        step_q;
    logic signed [ACC_W-1:0]  acc_q;

    logic                     trig;
    logic [TAPS_W-1:0]        taps_eff;
    logic [TAPS_W:0]          taps_p1;
    logic [TAPS_W-1:0]        need_c;
    logic [TAPS_W-1:0]        half_c;
    logic [TAPS_W-1:0]        steps_c;
    int unsigned              budget_i;
    logic                     over_c;

    logic [RING_AW-1:0]       wr_ptr;
    logic [RING_AW-1:0]       addr_a;
    logic [RING_AW-1:0]       addr_b;
    logic signed [DATA_W-1:0] smp_a;
    logic signed [DATA_W-1:0] smp_b;
    logic signed [COEF_W-1:0] coef_c;
    logic signed [PRE_W-1:0]  pre_c;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [DATA_W-1:0] rounded;

    // tap-count and budget evaluation
    always_comb begin
        if (!cfg_sym && (cfg_taps > TAPS_W'(MAX_ASYM_TAPS))) begin
            taps_eff = TAPS_W'(MAX_ASYM_TAPS);
        end else begin
            taps_eff = cfg_taps;
        end
        taps_p1  = {1'b0, taps_eff} + (TAPS_W + 1)'(1);
        half_c   = taps_eff >> 1;
        need_c   = cfg_sym ? taps_p1[TAPS_W:1] : taps_eff;
        budget_i = (int'(cfg_dec) + 1) * CLKS_PER_IN - 1;
        over_c   = int'(need_c) > budget_i;
        steps_c  = over_c ? TAPS_W'(budget_i) : need_c;
    end

    assign trig = in_valid && (phase_q == cfg_dec);

    symfir_sample_ring #(
        .DATA_W (DATA_W),
        .DEPTH  (RING_DEPTH)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_data   (in_data),
        .wr_ptr    (wr_ptr),
        .rd_addr_a (addr_a),
        .rd_addr_b (addr_b),
        .rd_a      (smp_a),
        .rd_b      (smp_b)
    );

    symfir_coef_bank #(
        .COEF_W (COEF_W),
        .N_COEF (N_COEF)
    ) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (step_q[CADDR_W-1:0]),
        .rdata (coef_c)
    );

    symfir_round_sat #(
        .ACC_W (ACC_W),
        .FRAC  (FRAC),
        .OUT_W (DATA_W)
    ) u_rs (
        .acc (acc_q),
        .y   (rounded)
    );

    // tap addressing and mirrored pre-adder
    always_comb begin
        addr_a = base_q - RING_AW'(step_q);
        addr_b = base_q - RING_AW'(taps_eff) + RING_AW'(1) + RING_AW'(step_q);
        if (cfg_sym && (step_q < half_c)) begin
            pre_c = cfg_odd_sym ? (PRE_W'(smp_a) - PRE_W'(smp_b))
                                : (PRE_W'(smp_a) + PRE_W'(smp_b));
        end else if (cfg_sym) begin
            pre_c = cfg_odd_sym ? '0 : PRE_W'(smp_a);
        end else begin
            pre_c = PRE_W'(smp_a);
        end
        prod_c = pre_c * coef_c;
    end

    // decimation phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (in_valid) begin
            phase_q <= trig ? '0 : phase_q + DEC_W'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_EMIT: begin
                if (trig) begin
                    state_d = (steps_c == '0) ? ST_EMIT : ST_MAC;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_MAC: begin
                if (step_q + TAPS_W'(1) == steps_c) begin
                    state_d = ST_EMIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // accumulate datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            step_q <= '0;
            acc_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_EMIT: begin
                    if (trig) begin
                        base_q <= wr_ptr;
                        step_q <= '0;
                        acc_q  <= '0;
                    end
                end
                ST_MAC: begin
                    acc_q  <= acc_q + prod_c;
                    step_q <= step_q + TAPS_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            over_budget <= 1'b0;
        end else begin
            out_valid   <= (state_q == ST_EMIT);
            over_budget <= over_c;
            if (state_q == ST_EMIT) begin
                out_data <= rounded;
            end
        end
    end
endmodule

// File: rtl/symfir_decim_sva.sv
module symfir_decim_sva #(
    parameter int DATA_W = 16,
    parameter int TAPS_W = 6,
    parameter int DEC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              over_budget,
    input logic              cfg_sym,
    input logic [TAPS_W-1:0] cfg_taps,
    input logic [DEC_W-1:0]  cfg_dec
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R7: the widest decimation leaves room for every legal tap count
    p_max_dec_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dec == '1) |=> !over_budget);

    p_zero_taps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_sym && (cfg_taps == '0)) |-> (out_data == '0));
endmodule

bind symfir_decim symfir_decim_sva #(
    .DATA_W (DATA_W),
    .TAPS_W (TAPS_W),
    .DEC_W  (DEC_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .over_budget (over_budget),
    .cfg_sym     (cfg_sym),
    .cfg_taps    (cfg_taps),
    .cfg_dec     (cfg_dec)
);

// File: tb/tb_symfir_decim.sv
module tb_symfir_decim;
    localparam int SPI  = 5;
    localparam int NOUT = 6;

    typedef struct packed {
        logic       sym;
        logic       odd;
        logic [5:0] taps;
        logic [2:0] dec;
        logic [1:0] pat;
        logic       ovr;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 6'd7,  3'd1, 2'd0, 1'b0},
        '{1'b1, 1'b1, 6'd7,  3'd3, 2'd0, 1'b0},
        '{1'b1, 1'b0, 6'd8,  3'd0, 2'd0, 1'b0},
        '{1'b1, 1'b1, 6'd8,  3'd2, 2'd0, 1'b0},
        '{1'b0, 1'b0, 6'd5,  3'd1, 2'd0, 1'b0},
        '{1'b1, 1'b0, 6'd63, 3'd7, 2'd0, 1'b0},
        '{1'b1, 1'b1, 6'd63, 3'd7, 2'd0, 1'b0},
        '{1'b0, 1'b0, 6'd32, 3'd7, 2'd0, 1'b0},
        '{1'b1, 1'b0, 6'd21, 3'd0, 2'd0, 1'b1},
        '{1'b0, 1'b0, 6'd40, 3'd6, 2'd0, 1'b0},
        '{1'b0, 1'b0, 6'd12, 3'd1, 2'd0, 1'b1},
        '{1'b1, 1'b0, 6'd8,  3'd1, 2'd1, 1'b0},
        '{1'b1, 1'b0, 6'd8,  3'd1, 2'd2, 1'b0},
        '{1'b1, 1'b1, 6'd5,  3'd2, 2'd0, 1'b0},
        '{1'b0, 1'b0, 6'd0,  3'd2, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        cfg_sym = 1'b0;
    logic        cfg_odd_sym = 1'b0;
    logic [5:0]  cfg_taps = '0;
    logic [2:0]  cfg_dec = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        over_budget;

    always #10 clk = ~clk;

    symfir_decim #(.CLKS_PER_IN(SPI)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .cfg_sym     (cfg_sym),
        .cfg_odd_sym (cfg_odd_sym),
        .cfg_taps    (cfg_taps),
        .cfg_dec     (cfg_dec),
        .coef_we     (coef_we),
        .coef_addr   (coef_addr),
        .coef_data   (coef_data),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .over_budget (over_budget)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          out_cnt = 0;
    bit          mon_en = 1'b0;
    bit          prev_ov = 1'b0;
    int unsigned seed = 32'h1234_5678;
    int          xs [512];
    int          hc [32];
    vec_t        cur;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    function automatic longint sx(input int m);
        return (m < 0) ? 64'sd0 : longint'(xs[m]);
    endfunction

    // reference convolution written from the requirements
    function automatic int ref_y(input int n);
        int     nt, need, bud, k;
        longint acc, v, r;
        nt   = cur.sym ? int'(cur.taps) : ((int'(cur.taps) > 32) ? 32 : int'(cur.taps));
        need = cur.sym ? (nt + 1) / 2 : nt;
        bud  = (int'(cur.dec) + 1) * SPI - 1;
        k    = (need > bud) ? bud : need;
        acc  = 0;
        for (int j = 0; j < k; j++) begin
            if (!cur.sym) v = sx(n - j);
            else if (2 * j + 1 < nt) v = cur.odd ? sx(n - j) - sx(n - nt + 1 + j)
                                                 : sx(n - j) + sx(n - nt + 1 + j);
            else v = cur.odd ? 64'sd0 : sx(n - j);
            acc += longint'(hc[j]) * v;
        end
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            int    d, e;
            string tag;
            d = int'(cur.dec) + 1;
            e = ref_y(out_cnt * d + d - 1);
            if (out_cnt == 0) tag = "R9 zero history";
            else if (cur.ovr) tag = "R7 truncated sum";
            else if (cur.pat != 0) tag = "R6 saturation";
            else if (!cur.sym) tag = "R5 asymmetric";
            else if (cur.odd) tag = "R4 odd symmetry";
            else tag = "R3 even symmetry";
            chk(int'($signed(out_data)) == e, tag, int'($signed(out_data)), e);
            chk(!prev_ov, "R8 single pulse", int'(prev_ov), 0);
            out_cnt++;
        end
        prev_ov = out_valid;
    end

    task automatic do_reset(input vec_t v);
        @(negedge clk);
        rst_n       = 1'b0;
        cfg_sym     = v.sym;
        cfg_odd_sym = v.odd;
        cfg_taps    = v.taps;
        cfg_dec     = v.dec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_coefs(input logic [1:0] pat);
        for (int j = 0; j < 32; j++) begin
            hc[j] = (pat == 2'd0) ? (rnd16() >>> 2) : 32767;
            @(negedge clk);
            coef_we   = 1'b1;
            coef_addr = 5'(j);
            coef_data = 16'(hc[j]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic feed(input int nin);
        for (int i = 0; i < nin; i++) begin
            in_valid = 1'b1;
            in_data  = 16'(xs[i]);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (SPI - 1) @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int nin;
        cur = v;
        do_reset(v);
        load_coefs(v.pat);
        nin = NOUT * (int'(v.dec) + 1);
        for (int i = 0; i < nin; i++) begin
            xs[i] = (v.pat == 2'd0) ? rnd16() : ((v.pat == 2'd1) ? 32767 : -32768);
        end
        out_cnt = 0;
        mon_en  = 1'b1;
        feed(nin);
        repeat (60) @(negedge clk);
        mon_en = 1'b0;
        chk(out_cnt == NOUT, "R2 output count", out_cnt, NOUT);
        chk(over_budget == v.ovr, "R7 over_budget flag", int'(over_budget), int'(v.ovr));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, checked before any clock edge after release
        do_reset(VECS[0]);
        chk(out_valid == 1'b0, "R1 out_valid at reset", int'(out_valid), 0);
        chk(out_data == 16'd0, "R1 out_data at reset", int'(out_data), 0);
        chk(over_budget == 1'b0, "R1 over_budget at reset", int'(over_budget), 0);

        for (int t = 0; t < NVEC; t++) begin
            run_vec(VECS[t]);
        end

        // R1: reset in the middle of a computation clears the output strobe
        cur = VECS[5];
        do_reset(VECS[5]);
        load_coefs(2'd0);
        for (int i = 0; i < 8; i++) xs[i] = rnd16();
        feed(8);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid during reset", int'(out_valid), 0);
        chk(out_data == 16'd0, "R1 out_data during reset", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 first cycle after reset", int'(out_valid), 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule